// File: doc/BRIEF.md
# SD Data-Line Block Transmitter

This block sends one data block from the host side onto the data lines of an SD card bus. Payload bytes arrive over a ready/valid byte stream. A one-byte holding register splits each byte into bus units: single bits on DAT0 in narrow mode, or nibbles across DAT3..DAT0 in wide mode. The transmitter frames the payload with a low start bit, a CRC16 for each active line and a high end bit. It then releases the lines, pulses `done` and waits a fixed quiet gap before it accepts the next request.

The same sequencer can also report the card as busy. It holds DAT0 low for a fixed number of bus periods, drives it high for one period and then releases it. Every change of state happens on a system clock edge where `strobe` is high, and each such edge stands for one SD clock period. A request is sampled only on such an edge while `idle` is high. The mode input is latched when a block starts.

Top module: `sd_dat_tx`

## Requirements
- R1: After reset `dat_oe` is 0000, `done` is 0, `idle` is 1 and `in_ready` is 0.
- R2: The first period of a block drives 0 on every active line, with `dat_oe` = 1111 in wide mode (`wide`=1) and 0001 in narrow mode (`wide`=0, DAT0 only).
- R3: Narrow mode sends each payload byte MSB first on DAT0. Wide mode sends the high nibble of each byte, then the low nibble, with byte bit 7 (or bit 3) on DAT3, so payload bit 4k appears on DAT3 and bit 4k+3 on DAT0.
- R4: Right after the payload, each active line sends 16 periods of its own CRC16, bit 15 first. The CRC uses polynomial 0x1021 with initial value 0 and covers only that line's payload bits.
- R5: After the CRC, each active line is driven to 1 for one period. On the next strobe edge `dat_oe` becomes 0000 and `done` is high for exactly one clock.
- R6: After the release edge, `idle` stays low for 8 strobe edges and rises on the 8th. Requests that arrive while `idle` is low have no effect on the lines.
- R7: A busy request drives DAT0 (`dat_oe`=0001) low for 10 periods and high for 1 period, then releases with a `done` pulse and the same gap as R6.
- R8: On clock edges where `strobe` is low, `dat_out` and `dat_oe` do not change.
- R9: If `start_blk` and `start_busy` are high together, a block starts.
- R10: `in_ready` is high only during the start and payload phases of a block, and at most the block's byte count is accepted per block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| strobe | input | 1 | One-cycle enable marking each SD clock period |
| wide | input | 1 | 1 = four-line mode, 0 = DAT0 only; latched at block start |
| start_blk | input | 1 | Request to send one block |
| start_busy | input | 1 | Request to signal busy on DAT0 |
| in_data | input | 8 | Payload byte |
| in_valid | input | 1 | Payload byte valid |
| in_ready | output | 1 | Payload byte accepted on this edge when valid |
| dat_out | output | 4 | Data value for DAT3..DAT0 |
| dat_oe | output | 4 | Per-line output enable |
| done | output | 1 | One-clock pulse when the lines are released |
| idle | output | 1 | Ready to accept a request |

## Verification
The checker assumes a synchronous reset and a `strobe` that is a single-clock pulse. It also assumes requests change only between edges. The bench drives every input on the falling clock edge and produces strobes with a divider of two or three clocks. The checker does not expect the transmitter to keep up when payload bytes arrive late: an empty holding register simply stalls the frame. The feeder therefore keeps `in_valid` high for each byte until it is taken, so no stall is ever exercised.

// File: rtl/sd_dat_tx_pkg.sv
package sd_dat_tx_pkg;

    localparam int LANES    = 4;
    localparam int CRC_W    = 16;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_PAY,
        ST_CRC,
        ST_END,
        ST_GAP,
        ST_BLO,
        ST_BHI
    } tx_state_e;

    // one serial step of the CRC16 divider
    function automatic logic [CRC_W-1:0] crc16_step(logic [CRC_W-1:0] c, logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    endfunction

endpackage

// File: rtl/sd_dat_crc_lane.sv
module sd_dat_crc_lane
    import sd_dat_tx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic upd,
    input  logic shf,
    input  logic bit_in,
    output logic msb
);
    logic [CRC_W-1:0] crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clr)      crc_d = '0;
        else if (upd) crc_d = crc16_step(crc_q, bit_in);
        else if (shf) crc_d = {crc_q[CRC_W-2:0], 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign msb = crc_q[CRC_W-1];
endmodule

// File: rtl/sd_dat_byte_buf.sv
module sd_dat_byte_buf #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept_en,
    input  logic              wide,
    input  logic              take,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              loaded,
    output logic              have,
    output logic [3:0]        unit
);
    localparam int IDX_W = $clog2(BYTE_W);

    typedef struct packed {
        logic [BYTE_W-1:0] byte_v;
        logic              full;
        logic [IDX_W-1:0]  idx;
    } buf_t;

    buf_t r_q, r_d;
    logic last_unit;

    assign last_unit = wide ? (r_q.idx == IDX_W'(1)) : (r_q.idx == IDX_W'(BYTE_W-1));
    assign in_ready  = accept_en && (!r_q.full || (take && last_unit));
    assign loaded    = in_ready && in_valid;
    assign have      = r_q.full;

    always_comb begin
        unit = 4'b0000;
        if (wide) begin
            unit = (r_q.idx == '0) ? r_q.byte_v[BYTE_W-1 -: 4] : r_q.byte_v[BYTE_W-5 -: 4];
        end else begin
            unit[0] = r_q.byte_v[IDX_W'(BYTE_W-1) - r_q.idx];
        end
    end

    always_comb begin
        r_d = r_q;
        if (take) begin
            if (last_unit) r_d.full = 1'b0;
            else           r_d.idx  = r_q.idx + IDX_W'(1);
        end
        if (loaded) begin
            r_d.byte_v = in_data;
            r_d.full   = 1'b1;
            r_d.idx    = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end
endmodule

// File: rtl/sd_dat_tx.sv
module sd_dat_tx
    import sd_dat_tx_pkg::*;
#(
    parameter int BLOCK_BYTES = 512,
    parameter int GAP_CYCLES  = 8,
    parameter int BUSY_CYCLES = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       strobe,
    input  logic       wide,
    input  logic       start_blk,
    input  logic       start_busy,
    input  logic [7:0] in_data,
    input  logic       in_valid,
    output logic       in_ready,
    output logic [3:0] dat_out,
    output logic [3:0] dat_oe,
    output logic       done,
    output logic       idle
);
    localparam int MAX_CNT = 8*BLOCK_BYTES + CRC_W + GAP_CYCLES + BUSY_CYCLES;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);
    localparam int LD_W    = $clog2(BLOCK_BYTES + 1);

    typedef struct packed {
        tx_state_e        st;
        logic             wide;
        logic [CNT_W-1:0] cnt;
        logic [LD_W-1:0]  ld;
        logic [3:0]       dat;
        logic [3:0]       oe;
        logic             done;
    } tx_t;

    tx_t r_q, r_d;

    logic             take, crc_clr, crc_upd, crc_shf;
    logic             accept_en, loaded, have;
    logic [3:0]       unit, crc_msb;
    logic [CNT_W-1:0] pay_units;

    assign pay_units = r_q.wide ? CNT_W'(2*BLOCK_BYTES) : CNT_W'(8*BLOCK_BYTES);
    assign accept_en = ((r_q.st == ST_START) || (r_q.st == ST_PAY)) &&
                       (r_q.ld < LD_W'(BLOCK_BYTES));

    sd_dat_byte_buf #(.BYTE_W(8)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept_en (accept_en),
        .wide      (r_q.wide),
        .take      (take),
        .in_data   (in_data),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .loaded    (loaded),
        .have      (have),
        .unit      (unit)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        sd_dat_crc_lane u_crc (
            .clk    (clk),
            .rst_n  (rst_n),
            .clr    (crc_clr),
            .upd    (crc_upd),
            .shf    (crc_shf),
            .bit_in (unit[g]),
            .msb    (crc_msb[g])
        );
    end

    always_comb begin
        r_d     = r_q;
        r_d.done = 1'b0;
        take    = 1'b0;
        crc_clr = 1'b0;
        crc_upd = 1'b0;
        crc_shf = 1'b0;
        if (loaded) r_d.ld = r_q.ld + LD_W'(1);
        if (strobe) begin
            unique case (r_q.st)
                ST_IDLE: begin
                    if (start_blk) begin
                        r_d.st   = ST_START;
                        r_d.wide = wide;
                        r_d.oe   = wide ? 4'b1111 : 4'b0001;
                        r_d.dat  = 4'b0000;
                        r_d.cnt  = '0;
                        r_d.ld   = '0;
                        crc_clr  = 1'b1;
                    end else if (start_busy) begin
                        r_d.st  = ST_BLO;
                        r_d.oe  = 4'b0001;
                        r_d.dat = 4'b0000;
                        r_d.cnt = CNT_W'(1);
                    end
                end
                ST_START, ST_PAY: begin
                    if (r_q.st == ST_PAY && r_q.cnt == pay_units) begin
                        r_d.st  = ST_CRC;
                        r_d.dat = crc_msb & r_q.oe;
                        r_d.cnt = CNT_W'(1);
                        crc_shf = 1'b1;
                    end else if (have) begin
                        take    = 1'b1;
                        crc_upd = 1'b1;
                        r_d.st  = ST_PAY;
                        r_d.dat = unit & r_q.oe;
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                ST_CRC: begin
                    if (r_q.cnt == CNT_W'(CRC_W)) begin
                        r_d.st  = ST_END;
                        r_d.dat = r_q.oe;
                    end else begin
                        r_d.dat = crc_msb & r_q.oe;
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                        crc_shf = 1'b1;
                    end
                end
                ST_END, ST_BHI: begin
                    r_d.st   = ST_GAP;
                    r_d.oe   = 4'b0000;
                    r_d.dat  = 4'b0000;
                    r_d.done = 1'b1;
                    r_d.cnt  = CNT_W'(1);
                end
                ST_GAP: begin
                    if (r_q.cnt == CNT_W'(GAP_CYCLES)) r_d.st = ST_IDLE;
                    else r_d.cnt = r_q.cnt + CNT_W'(1);
                end
                ST_BLO: begin
                    if (r_q.cnt == CNT_W'(BUSY_CYCLES)) begin
                        r_d.st  = ST_BHI;
                        r_d.dat = 4'b0001;
                    end else begin
                        r_d.cnt = r_q.cnt + CNT_W'(1);
                    end
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign dat_out = r_q.dat;
    assign dat_oe  = r_q.oe;
    assign done    = r_q.done;
    assign idle    = (r_q.st == ST_IDLE);
endmodule

// File: rtl/sd_dat_tx_chk.sv
module sd_dat_tx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       strobe,
    input logic       in_ready,
    input logic [3:0] dat_out,
    input logic [3:0] dat_oe,
    input logic       done,
    input logic       idle
);
    p_hold_no_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> ($stable(dat_out) && $stable(dat_oe)));

    p_oe_shape_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_oe == 4'b0000) || (dat_oe == 4'b0001) || (dat_oe == 4'b1111));

    p_release_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dat_oe != 4'b0000) |-> done);

    p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_lines_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (dat_oe == 4'b0000));

    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (dat_oe == 4'b0000));

    p_ready_busy_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> !idle);
endmodule

bind sd_dat_tx sd_dat_tx_chk u_chk (.*);

// File: tb/sd_dat_tx_test.sv
module sd_dat_tx_test;
    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       strobe = 1'b0;
    logic       wide = 1'b0;
    logic       start_blk = 1'b0;
    logic       start_busy = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [3:0] dat_out, dat_oe;
    logic       done, idle;

    int checks = 0;
    int errors = 0;
    int stb_div = 2;
    int cyc = 0;
    logic [3:0] prev_dat, prev_oe;

    // vector: [38] wide, [37:32] frame length in periods, [31:0] payload (first byte in [31:24])
    localparam logic [38:0] VEC [6] = '{
        {1'b0, 6'd50, 32'hA5C3_0F81},
        {1'b1, 6'd26, 32'hA5C3_0F81},
        {1'b0, 6'd50, 32'h0000_0000},
        {1'b1, 6'd26, 32'hFFFF_FFFF},
        {1'b1, 6'd26, 32'h1234_5678},
        {1'b0, 6'd50, 32'h8000_0001}
    };

    sd_dat_tx #(.BLOCK_BYTES(NB), .GAP_CYCLES(8), .BUSY_CYCLES(10)) uut (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .wide(wide),
        .start_blk(start_blk), .start_busy(start_busy),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .dat_out(dat_out), .dat_oe(dat_oe), .done(done), .idle(idle)
    );

    always #4 clk = ~clk;

    initial begin
        forever begin
            @(negedge clk);
            cyc = cyc + 1;
            strobe <= (cyc % stb_div == 0);
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors = errors + 1;
        $display("FAIL watchdog: run did not end, actual hung expected finished");
        summary();
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks = checks + 1;
        if (act !== exp) begin
            errors = errors + 1;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] crc_bit(logic [15:0] c, logic b);
        logic [15:0] n;
        n = {c[14:0], 1'b0};
        if (b ^ c[15]) n = n ^ 16'h1021;
        return n;
    endfunction

    // advance to the negedge after the next strobe edge; checks R8 on the way
    task automatic next_strobe();
        logic s;
        s = 1'b0;
        while (!s) begin
            @(posedge clk);
            s = strobe;
            @(negedge clk);
            if (!s) begin
                chk("R8 hold dat", {4'h0, dat_out}, {4'h0, prev_dat});
                chk("R8 hold oe", {4'h0, dat_oe}, {4'h0, prev_oe});
            end
            prev_dat = dat_out;
            prev_oe  = dat_oe;
        end
    endtask

    task automatic feed(input logic [31:0] d);
        for (int b = 0; b < NB; b++) begin
            @(negedge clk);
            in_data  = d[31-8*b -: 8];
            in_valid = 1'b1;
            #1;
            while (!in_ready) begin
                @(negedge clk);
                #1;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic wait_drive();
        do @(negedge clk); while (dat_oe == 4'b0000);
        prev_dat = dat_out;
        prev_oe  = dat_oe;
        start_blk  = 1'b0;
        start_busy = 1'b0;
    endtask

    task automatic gap_check(input logic busy_req);
        int n;
        next_strobe();
        chk("R5 release oe", {4'h0, dat_oe}, 8'h00);
        chk("R5 done pulse", {7'h0, done}, 8'h01);
        @(negedge clk);
        chk("R5 done single", {7'h0, done}, 8'h00);
        prev_dat = dat_out;
        prev_oe  = dat_oe;
        if (busy_req) start_busy = 1'b1;
        n = 0;
        while (!idle) begin
            next_strobe();
            n = n + 1;
            chk("R6 quiet in gap", {4'h0, dat_oe}, 8'h00);
            chk("R10 no ready in gap", {7'h0, in_ready}, 8'h00);
        end
        chk("R6 gap length", 8'(n), 8'd8);
    endtask

    task automatic run_frame(input logic w, input logic [31:0] d, input int len, input logic both);
        logic [3:0]  ed[64];
        logic [3:0]  eo[64];
        logic [15:0] c[4];
        int k;
        for (int l = 0; l < 4; l++) c[l] = 16'h0;
        ed[0] = 4'h0;
        k = 1;
        if (w) begin
            for (int i = 0; i < 2*NB; i++) begin
                ed[k] = d[31-4*i -: 4];
                for (int l = 0; l < 4; l++) c[l] = crc_bit(c[l], ed[k][l]);
                k = k + 1;
            end
        end else begin
            for (int i = 0; i < 8*NB; i++) begin
                ed[k] = {3'b000, d[31-i]};
                c[0] = crc_bit(c[0], d[31-i]);
                k = k + 1;
            end
        end
        for (int j = 15; j >= 0; j--) begin
            ed[k] = w ? {c[3][j], c[2][j], c[1][j], c[0][j]} : {3'b000, c[0][j]};
            k = k + 1;
        end
        ed[k] = w ? 4'hF : 4'h1;
        k = k + 1;
        for (int i = 0; i < k; i++) eo[i] = w ? 4'hF : 4'h1;
        chk("R3 frame length", 8'(k), 8'(len));

        @(negedge clk);
        wide = w;
        start_blk = 1'b1;
        if (both) start_busy = 1'b1;
        fork
            feed(d);
            begin
                wait_drive();
                chk("R2 start bit", {4'h0, dat_out}, {4'h0, ed[0]});
                chk(both ? "R9 block wins oe" : "R2 start oe", {4'h0, dat_oe}, {4'h0, eo[0]});
                for (int i = 1; i < k; i++) begin
                    next_strobe();
                    if (i <= (w ? 2*NB : 8*NB))
                        chk("R3 payload", {4'h0, dat_out}, {4'h0, ed[i]});
                    else if (i < k - 1)
                        chk("R4 crc", {4'h0, dat_out}, {4'h0, ed[i]});
                    else
                        chk("R5 end bit", {4'h0, dat_out}, {4'h0, ed[i]});
                    chk("R2 oe held", {4'h0, dat_oe}, {4'h0, eo[i]});
                end
            end
        join
    endtask

    task automatic busy_check();
        if (dat_oe == 4'b0000) begin
            start_busy = 1'b1;
            wait_drive();
        end else begin
            start_busy = 1'b0;
        end
        chk("R7 busy low oe", {4'h0, dat_oe}, 8'h01);
        chk("R7 busy low", {4'h0, dat_out}, 8'h00);
        for (int i = 1; i < 10; i++) begin
            next_strobe();
            chk("R7 busy low", {4'h0, dat_out}, 8'h00);
        end
        next_strobe();
        chk("R7 busy high", {4'h0, dat_out}, 8'h01);
        chk("R7 busy high oe", {4'h0, dat_oe}, 8'h01);
        gap_check(1'b0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1 oe", {4'h0, dat_oe}, 8'h00);
        chk("R1 done", {7'h0, done}, 8'h00);
        chk("R1 idle", {7'h0, idle}, 8'h01);
        chk("R1 in_ready", {7'h0, in_ready}, 8'h00);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        for (int v = 0; v < 6; v++) begin
            stb_div = (v % 2 == 0) ? 2 : 3;
            run_frame(VEC[v][38], VEC[v][31:0], int'(VEC[v][37:32]), 1'b0);
            gap_check(1'b0);
        end

        // R9 both requests together, then R6 busy request held through the gap
        stb_div = 2;
        run_frame(1'b1, 32'hDEAD_BEEF, 26, 1'b1);
        gap_check(1'b1);
        // idle reached with busy pending: busy starts at the next strobe
        wait_drive();
        busy_check();

        // R7 busy from idle with strobe divider of three
        stb_div = 3;
        busy_check();
        chk("R10 idle no ready", {7'h0, in_ready}, 8'h00);
        summary();
    end
endmodule